// File: doc/BRIEF.md
# Interconnect Test Sequencer

This block applies a set of serial code words to a group of board nets and decides, net by net, whether each one is connected correctly. Every net gets its own code word. One bit of every word goes out in parallel on each step, so a run of `WORD_W` steps sends the whole code set. The word that comes back on each net is collected bit by bit. When the run is over, each net is marked good, open or shorted.

A code word is the net's index plus one. This keeps the all-zero and all-one words out of use. One extra bit, fixed at one, is added above the code bits. A wired-AND short between nets whose codes share no bits would otherwise produce an all-zero result, and that would look like an open. The extra bit survives any AND of driven words, so only a genuinely undriven receiver reads all zeros. A single start pulse launches a run. A done flag and the per-net diagnosis then stay in place until the next start is accepted.

Top module: `icn_test_seq`

## Requirements
- R1: After synchronous reset, `done_o` is 0, `drive_o` is all zeros and every diagnosis field is 00.
- R2: The code word of net i is `WORD_W = CODE_W + 1` bits wide, with `CODE_W = ceil(log2(NETS+2))`. Bits `CODE_W-1..0` hold the value i+1 and bit `CODE_W` is 1.
- R3: In the cycle after an accepted start, `drive_o[i]` carries bit 0 of net i's word. Each following cycle advances by one bit, least significant first, through bit `WORD_W-1`.
- R4: `drive_o` is all zeros whenever no run is in progress.
- R5: `done_o` goes high `WORD_W+1` rising edges after the edge that accepts start. It is low from that accepting edge until then.
- R6: Diagnosis field i, `diag_o[2i+1:2i]`, is 00 (good) when the word received on net i equals its driven word.
- R7: The diagnosis field is 01 (open) when the received word is all zeros.
- R8: The diagnosis field is 10 (shorted) for any other received word. The value 11 never appears.
- R9: A wired-AND short between nets whose code bits do not overlap is reported as shorted on both nets, not as open.
- R10: Once a run ends, `done_o` and `diag_o` hold their values, whatever `rx_i` does, until the next accepted start.
- R11: A start pulse that arrives while a run is in progress is ignored. The run's timing and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a run when none is in progress |
| rx_i | input | NETS | Received level on each net |
| drive_o | output | NETS | Current code bit driven on each net |
| diag_o | output | 2*NETS | Two-bit diagnosis per net: 00 good, 01 open, 10 shorted |
| done_o | output | 1 | High once diagnosis of the last run is ready |

## Verification
The bench builds the block with NETS = 6. That gives three code bits plus the marker bit, and the codes 1 to 6 fill every usable value of a 3-bit code: the next net would need the forbidden all-one word. This choice puts the tightest code space within reach. Nets 0 and 1 (codes 001 and 010) make the disjoint-code short that only the marker bit can separate from an open, and nets 0 and 2 (codes 001 and 011) make a short in which one net still reads its own word. Random fault patterns mix opens with two independent short groups on top of these directed cases.

// File: rtl/ict_pkg.sv
package ict_pkg;
  typedef enum logic [1:0] {
    NET_GOOD  = 2'b00,
    NET_OPEN  = 2'b01,
    NET_SHORT = 2'b10
  } net_diag_e;
endpackage

// File: rtl/ict_codebook.sv
module ict_codebook #(
  parameter int NETS   = 6,
  parameter int CODE_W = $clog2(NETS + 2),
  parameter int WORD_W = CODE_W + 1
) (
  output logic [NETS*WORD_W-1:0] words_o
);
  // Each net gets index+1 in the code bits and a marker bit of 1 on top
  for (genvar i = 0; i < NETS; i++) begin : g_word
    assign words_o[i*WORD_W +: WORD_W] = {1'b1, CODE_W'(i + 1)};
  end
endmodule

// File: rtl/ict_seq_ctrl.sv
module ict_seq_ctrl #(
  parameter int WORD_W = 4,
  parameter int STEP_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              go_o,
  output logic              run_o,
  output logic              last_o,
  output logic              fin_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o,
  output logic [STEP_W-1:0] nstep_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(WORD_W - 1);

  logic              run_q, fin_q, done_q;
  logic [STEP_W-1:0] step_q;

  assign go_o    = start_i && !run_q;
  assign run_o   = run_q;
  assign last_o  = run_q && (step_q == LAST_STEP);
  assign fin_o   = fin_q;
  assign done_o  = done_q;
  assign step_o  = step_q;
  assign nstep_o = go_o ? '0 : step_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      step_q <= '0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      fin_q <= last_o;
      if (go_o) begin
        run_q  <= 1'b1;
        step_q <= '0;
      end else if (run_q) begin
        if (last_o) begin
          run_q  <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
      if (go_o)       done_q <= 1'b0;
      else if (fin_q) done_q <= 1'b1;
    end
  end

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (step_q <= LAST_STEP));
  // R5
  done_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(fin_q));
  // R5
  done_run_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_q && run_q));
  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !last_o) |=> (step_q == $past(step_q) + 1'b1));
endmodule

// File: rtl/ict_capture.sv
module ict_capture #(
  parameter int NETS   = 6,
  parameter int WORD_W = 4,
  parameter int STEP_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap_en_i,
  input  logic [STEP_W-1:0]      step_i,
  input  logic [NETS-1:0]        rx_i,
  output logic [NETS*WORD_W-1:0] rxw_o
);
  for (genvar i = 0; i < NETS; i++) begin : g_net
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (cap_en_i) word_q[step_i] <= rx_i[i];
    end
    assign rxw_o[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/ict_classify.sv
module ict_classify
  import ict_pkg::*;
#(
  parameter int NETS   = 6,
  parameter int WORD_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fin_i,
  input  logic [NETS*WORD_W-1:0] words_i,
  input  logic [NETS*WORD_W-1:0] rxw_i,
  output logic [2*NETS-1:0]      diag_o
);
  for (genvar i = 0; i < NETS; i++) begin : g_net
    net_diag_e         st_q;
    logic [WORD_W-1:0] got, want;
    assign got  = rxw_i[i*WORD_W +: WORD_W];
    assign want = words_i[i*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
      if (rst) st_q <= NET_GOOD;
      else if (fin_i) begin
        if (got == want)    st_q <= NET_GOOD;
        else if (got == '0) st_q <= NET_OPEN;
        else                st_q <= NET_SHORT;
      end
    end
    assign diag_o[2*i +: 2] = st_q;

    // R8
    diag_code_chk: assert property (@(posedge clk) disable iff (rst)
      diag_o[2*i +: 2] != 2'b11);
    // R10
    diag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(fin_i) |-> $stable(diag_o[2*i +: 2]));
  end
endmodule

// File: rtl/icn_test_seq.sv
module icn_test_seq #(
  parameter int NETS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [NETS-1:0]   rx_i,
  output logic [NETS-1:0]   drive_o,
  output logic [2*NETS-1:0] diag_o,
  output logic              done_o
);
  localparam int CODE_W = $clog2(NETS + 2);
  localparam int WORD_W = CODE_W + 1;
  localparam int STEP_W = $clog2(WORD_W);

  logic [NETS*WORD_W-1:0] words, rxw;
  logic                   go, run, last, fin;
  logic [STEP_W-1:0]      step, nstep;
  logic [NETS-1:0]        slice;
  logic [NETS-1:0]        drive_q;

  ict_codebook #(.NETS(NETS), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_book (
    .words_o(words)
  );

  ict_seq_ctrl #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .go_o(go), .run_o(run), .last_o(last), .fin_o(fin),
    .done_o(done_o), .step_o(step), .nstep_o(nstep)
  );

  // Pick the next bit-slice to present on the nets
  for (genvar i = 0; i < NETS; i++) begin : g_slice
    assign slice[i] = words[i*WORD_W + int'(nstep)];
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= '0;
    else if (go || (run && !last)) drive_q <= slice;
    else drive_q <= '0;
  end
  assign drive_o = drive_q;

  ict_capture #(.NETS(NETS), .WORD_W(WORD_W), .STEP_W(STEP_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en_i(run), .step_i(step),
    .rx_i(rx_i), .rxw_o(rxw)
  );

  ict_classify #(.NETS(NETS), .WORD_W(WORD_W)) u_cls (
    .clk(clk), .rst(rst), .fin_i(fin),
    .words_i(words), .rxw_i(rxw), .diag_o(diag_o)
  );

  // R4
  idle_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> (drive_o == '0));
  // R3
  first_slice_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (drive_o == {NETS{1'b1}} || drive_o != '0));
endmodule

// File: tb/tb_icn_test_seq.sv
module tb_icn_test_seq;
  localparam int NETS = 6;
  localparam int CW   = $clog2(NETS + 2);
  localparam int WW   = CW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [NETS-1:0]   rx_i;
  logic [NETS-1:0]   drive_o;
  logic [2*NETS-1:0] diag_o;
  logic              done_o;

  logic [NETS-1:0] open_n;
  int              grp [NETS];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  icn_test_seq #(.NETS(NETS)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .rx_i(rx_i),
    .drive_o(drive_o), .diag_o(diag_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  // Board model: open reads 0, shorted groups read wired AND
  always_comb begin
    for (int i = 0; i < NETS; i++) begin
      logic v;
      v = drive_o[i];
      if (grp[i] != 0)
        for (int j = 0; j < NETS; j++)
          if (grp[j] == grp[i]) v = v & drive_o[j];
      rx_i[i] = open_n[i] ? 1'b0 : v;
    end
  end

  function automatic logic [WW-1:0] code_of(int i);
    return WW'((1 << CW) | (i + 1));
  endfunction

  function automatic logic [WW-1:0] exp_rx(int i);
    logic [WW-1:0] w;
    if (open_n[i]) return '0;
    w = code_of(i);
    if (grp[i] != 0)
      for (int j = 0; j < NETS; j++)
        if (grp[j] == grp[i]) w = w & code_of(j);
    return w;
  endfunction

  function automatic logic [1:0] exp_diag(int i);
    logic [WW-1:0] r;
    r = exp_rx(i);
    if (r == code_of(i)) return 2'b00;
    if (r == '0)         return 2'b01;
    return 2'b10;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    open_n = '0;
    for (int i = 0; i < NETS; i++) grp[i] = 0;
  endtask

  // One complete run; optional extra start pulse mid-run (R11)
  task automatic run_once(input bit extra_start);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(done_o == 1'b0, "R5 done low after start", done_o, 0);
    for (int k = 0; k < WW; k++) begin
      logic [NETS-1:0] e;
      for (int i = 0; i < NETS; i++) e[i] = code_of(i)[k];
      // R2 R3 code bit k on every net
      chk(drive_o == e, "R3 drive slice", drive_o, e);
      if (extra_start && k == 1) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(drive_o == '0, "R4 drive idle", drive_o, 0);
    chk(done_o == 1'b0, "R5 done not yet", done_o, 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R5 done timing", done_o, 1);
    for (int i = 0; i < NETS; i++)
      chk(diag_o[2*i +: 2] == exp_diag(i), "R6 R7 R8 diag", diag_o[2*i +: 2], exp_diag(i));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [2*NETS-1:0] held;
    void'($urandom(32'd20240611));
    clear_faults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(drive_o == '0, "R1 drive", drive_o, 0);
    chk(diag_o == '0, "R1 diag", diag_o, 0);

    // R6 all good
    run_once(1'b0);
    // R7 all open
    open_n = '1;
    run_once(1'b0);
    // R9 disjoint-code short: nets 0 and 1
    clear_faults(); grp[0] = 1; grp[1] = 1;
    run_once(1'b0);
    chk(diag_o[1:0] == 2'b10, "R9 net0 short", diag_o[1:0], 2);
    chk(diag_o[3:2] == 2'b10, "R9 net1 short", diag_o[3:2], 2);
    // overlapping codes: nets 0 and 2
    clear_faults(); grp[0] = 1; grp[2] = 1;
    run_once(1'b0);
    // R10 hold while rx changes
    held = diag_o;
    clear_faults(); open_n = '1;
    repeat (4) @(negedge clk);
    chk(diag_o == held, "R10 diag hold", diag_o, held);
    chk(done_o == 1'b1, "R10 done hold", done_o, 1);
    // R11 start during run ignored
    clear_faults(); grp[3] = 2; grp[5] = 2; open_n[1] = 1'b1;
    run_once(1'b1);

    for (int n = 0; n < 40; n++) begin
      clear_faults();
      for (int i = 0; i < NETS; i++) begin
        int r;
        r = int'($urandom % 8);
        if (r == 0) open_n[i] = 1'b1;
        else if (r <= 2) grp[i] = r;
      end
      run_once(n % 7 == 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule